// File: doc/BRIEF.md
# Interlocked Read-Modify-Write Memory Arbiter

This block fronts a shared word memory for several requesters, such as processors and I/O engines. Each requester has its own command port with a valid/ready handshake. Each port carries a command, a byte address and write data. The block grants at most one command per cycle, in round-robin order. It returns a single registered response that is tagged with the requester index.

Besides ordinary reads and writes, the block supports atomic read-modify-write through two paired commands. An interlock-read returns the current word and records a lock for the issuing requester on the region that holds the address. A later write-unlock from that same requester writes the new value back and drops the lock in the same operation. While the lock is held, interlock-reads from other requesters to the same region are held off: their ready stays low. Ordinary traffic keeps flowing, even to the locked word.

The lock region is the byte address with its `LOCK_SHIFT` low bits cleared. With the default of 2, a region is one aligned 32-bit word. Raising `LOCK_SHIFT` to `ADDR_W` makes the whole memory a single region.

Top module: `imem_interlock_arbiter`

## Requirements
- R1: Command code 0 is a read. A handshake (valid and ready both high at a clock edge) yields, one cycle later, `rsp_valid`=1 with `rsp_id` = the requester index and `rsp_data` = the word at `addr[ADDR_W-1:2]`. In a cycle after an edge with no handshake, `rsp_valid` is 0.
- R2: Command code 1 is a write. It stores `wdata` at the addressed word and answers with `rsp_data`=0 and `rsp_err`=0.
- R3: Command code 2 is an interlock-read. It returns the addressed word and records a lock for the issuing requester on the address's region. While that lock is held, an interlock-read from any other requester to the same region keeps ready low and gets no response.
- R4: Reads and writes are never stalled by a held lock, including reads and writes to the locked region.
- R5: Command code 3 is a write-unlock. From the lock holder with an address inside its locked region, it writes `wdata`, clears the lock and answers with data 0 and error 0. A stalled interlock-read can then be granted in the following cycle.
- R6: A write-unlock from a requester that holds no lock, or that holds a lock on a different region, answers with `rsp_err`=1 and data 0. It leaves the memory and all locks unchanged.
- R7: An interlock-read from a requester that already holds a lock answers with `rsp_err`=1 and data 0. The existing lock is kept unchanged.
- R8: At most one requester is granted per cycle. Arbitration is round-robin: after a grant to requester k, the search for the next grant starts at requester k+1 (wrapping to 0) and takes the first eligible requester.
- R9: A lock region is the byte address with its `LOCK_SHIFT` low bits cleared. `LOCK_SHIFT`=2 gives one aligned 32-bit word. `LOCK_SHIFT`=`ADDR_W` makes any held lock stall interlock-reads from every other requester to every address.
- R10: After reset, `rsp_valid` is 0, no locks are held, and requester 0 has first priority.
- R11: No two requesters ever hold locks on the same region at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_REQ | Per-requester command valid |
| req_ready | output | N_REQ | Per-requester grant; a handshake happens when valid and ready are both high at the edge |
| req_cmd | input | N_REQ*2 | Per-requester command: 0 read, 1 write, 2 interlock-read, 3 write-unlock |
| req_addr | input | N_REQ*ADDR_W | Per-requester byte address |
| req_wdata | input | N_REQ*DATA_W | Per-requester write data |
| rsp_valid | output | 1 | Response valid, one cycle after a handshake |
| rsp_id | output | IDW | Index of the requester being answered |
| rsp_data | output | DATA_W | Read data, or 0 for writes and errors |
| rsp_err | output | 1 | Command rejected by the lock rules |

## Verification
Some properties are checked by assertions on every cycle:
- grants are one-hot and only go to eligible requesters;
- a stalled interlock-read is never granted;
- pending reads and writes always win a grant;
- responses follow handshakes exactly one cycle later;
- locks are set by an accepted interlock-read, cleared by a matching write-unlock, and kept across a rejected repeat;
- two requesters never hold the same region;
- rejected commands leave the memory unchanged.

Only the bench scenarios show the rest. These are the returned data values, the exact round-robin order, and the release-then-grant handoff between stalled requesters. They also cover the contrast between the one-word and whole-memory region settings, which the bench runs side by side under the same stimulus.

// File: rtl/imem_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the interlocked memory arbiter.
// Assumes a two-bit command field on every requester port.
package imem_pkg;
    typedef enum logic [1:0] {
        CMD_READ     = 2'd0,
        CMD_WRITE    = 2'd1,
        CMD_LOCK_RD  = 2'd2,
        CMD_UNLOCK_WR = 2'd3
    } imem_cmd_e;
endpackage

// File: rtl/imem_rr_arb.sv
`timescale 1ns/1ps
// Round-robin arbiter: grants the first eligible requester starting at a
// rotating pointer, at most one per cycle. Assumes elig is stable within
// a cycle; the pointer moves one past the winner after each grant.
module imem_rr_arb #(
    parameter int N_REQ = 3,
    parameter int IDW   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] elig,
    output logic [N_REQ-1:0] grant,
    output logic [IDW-1:0]   grant_id,
    output logic             grant_any
);
    logic [IDW-1:0] ptr;

    // Pick the first eligible requester at or after the pointer.
    always_comb begin
        int idx;
        grant     = '0;
        grant_id  = '0;
        grant_any = 1'b0;
        for (int off = 0; off < N_REQ; off++) begin
            idx = (int'(ptr) + off) % N_REQ;
            if (!grant_any && elig[idx]) begin
                grant_any  = 1'b1;
                grant_id   = IDW'(idx);
                grant[idx] = 1'b1;
            end
        end
    end

    // Rotate priority to the requester after the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (grant_any) begin
            ptr <= (grant_id == IDW'(N_REQ - 1)) ? '0 : grant_id + 1'b1;
        end
    end

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R8
    grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~elig) == '0);
endmodule

// File: rtl/imem_lock_table.sv
`timescale 1ns/1ps
// Lock table: one lock slot per requester holding a region tag. Flags
// interlock-reads that hit another requester's region, and judges the
// granted command against the lock rules. Assumes one grant per cycle.
module imem_lock_table
    import imem_pkg::*;
#(
    parameter int N_REQ      = 3,
    parameter int IDW        = 2,
    parameter int ADDR_W     = 8,
    parameter int LOCK_SHIFT = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_REQ-1:0][1:0]         req_cmd,
    input  logic [N_REQ-1:0][ADDR_W-1:0]  req_addr,
    input  logic                          grant_any,
    input  logic [IDW-1:0]                grant_id,
    output logic [N_REQ-1:0]              blocked,
    output logic                          grant_err
);
    localparam logic [ADDR_W-1:0] REGION_MASK = {ADDR_W{1'b1}} << LOCK_SHIFT;

    logic [N_REQ-1:0]             lock_vld;
    logic [N_REQ-1:0][ADDR_W-1:0] lock_tag;
    imem_cmd_e                    g_cmd;
    logic [ADDR_W-1:0]            g_tag;
    logic                         g_held;
    logic                         g_hit;
    logic                         unlock_ok;
    logic                         lock_set;

    // Mark interlock-reads whose region is held by another requester.
    always_comb begin
        blocked = '0;
        for (int i = 0; i < N_REQ; i++) begin
            for (int j = 0; j < N_REQ; j++) begin
                if (j != i && lock_vld[j] && imem_cmd_e'(req_cmd[i]) == CMD_LOCK_RD
                    && lock_tag[j] == (req_addr[i] & REGION_MASK)) begin
                    blocked[i] = 1'b1;
                end
            end
        end
    end

    // Judge the granted command against its requester's own lock slot.
    always_comb begin
        g_cmd     = imem_cmd_e'(req_cmd[grant_id]);
        g_tag     = req_addr[grant_id] & REGION_MASK;
        g_held    = lock_vld[grant_id];
        g_hit     = g_held && (lock_tag[grant_id] == g_tag);
        unlock_ok = grant_any && g_cmd == CMD_UNLOCK_WR && g_hit;
        lock_set  = grant_any && g_cmd == CMD_LOCK_RD && !g_held;
        grant_err = grant_any && ((g_cmd == CMD_LOCK_RD && g_held) ||
                                  (g_cmd == CMD_UNLOCK_WR && !g_hit));
    end

    // Set a lock on an accepted interlock-read, drop it on a matching unlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_vld <= '0;
            lock_tag <= '0;
        end else if (lock_set) begin
            lock_vld[grant_id] <= 1'b1;
            lock_tag[grant_id] <= g_tag;
        end else if (unlock_ok) begin
            lock_vld[grant_id] <= 1'b0;
        end
    end

    for (genvar i = 0; i < N_REQ; i++) begin : g_slot_chk
        // R3
        stall_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            blocked[i] |-> !(grant_any && grant_id == IDW'(i)));
        // R3
        lock_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_any && grant_id == IDW'(i) && g_cmd == CMD_LOCK_RD && !lock_vld[i])
            |=> lock_vld[i]);
        // R5
        unlock_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (unlock_ok && grant_id == IDW'(i)) |=> !lock_vld[i]);
        // R7
        relock_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_any && grant_id == IDW'(i) && g_cmd == CMD_LOCK_RD && lock_vld[i])
            |=> (lock_vld[i] && $stable(lock_tag[i])));
        for (genvar j = i + 1; j < N_REQ; j++) begin : g_pair
            // R11
            lock_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(lock_vld[i] && lock_vld[j] && lock_tag[i] == lock_tag[j]));
        end
    end
endmodule

// File: rtl/imem_store.sv
`timescale 1ns/1ps
// Word store and response register. Executes the granted command one edge
// after the grant decision; rejected commands neither write nor return data.
// Assumes word-indexed addresses (byte address bits [1:0] dropped upstream).
module imem_store
    import imem_pkg::*;
#(
    parameter int IDW    = 2,
    parameter int WIDX_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  imem_cmd_e         cmd,
    input  logic [WIDX_W-1:0] word_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDW-1:0]    id,
    input  logic              err,
    output logic              rsp_valid,
    output logic [IDW-1:0]    rsp_id,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err
);
    localparam int DEPTH = 1 << WIDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              do_write;
    logic              do_read;

    // Decode whether the accepted command writes or returns data.
    always_comb begin
        do_write = fire && !err && (cmd == CMD_WRITE || cmd == CMD_UNLOCK_WR);
        do_read  = !err && (cmd == CMD_READ || cmd == CMD_LOCK_RD);
    end

    // Write accepted data into the word array.
    always_ff @(posedge clk) begin
        if (do_write) begin
            mem[word_idx] <= wdata;
        end
    end

    // Register the response for the command accepted this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                rsp_id   <= id;
                rsp_err  <= err;
                rsp_data <= do_read ? mem[word_idx] : '0;
            end
        end
    end

    // R1
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rsp_valid);
    // R1
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !rsp_valid);
    // R6
    err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && err) |=> (mem[$past(word_idx)] == $past(mem[word_idx])));
endmodule

// File: rtl/imem_interlock_arbiter.sv
`timescale 1ns/1ps
// Interlocked memory arbiter top. Per-requester valid/ready command ports
// feed a round-robin arbiter; interlock-reads hitting another requester's
// locked region are withheld from arbitration. The granted command runs in
// the word store, and its response appears one cycle after the handshake.
// Assumes 2 <= LOCK_SHIFT <= ADDR_W and byte addresses of 32-bit words.
module imem_interlock_arbiter
    import imem_pkg::*;
#(
    parameter int N_REQ      = 3,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int LOCK_SHIFT = 2,
    parameter int IDW        = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_REQ-1:0]              req_valid,
    output logic [N_REQ-1:0]              req_ready,
    input  logic [N_REQ-1:0][1:0]         req_cmd,
    input  logic [N_REQ-1:0][ADDR_W-1:0]  req_addr,
    input  logic [N_REQ-1:0][DATA_W-1:0]  req_wdata,
    output logic                          rsp_valid,
    output logic [IDW-1:0]                rsp_id,
    output logic [DATA_W-1:0]             rsp_data,
    output logic                          rsp_err
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [N_REQ-1:0]  blocked;
    logic [N_REQ-1:0]  elig;
    logic [N_REQ-1:0]  grant;
    logic [N_REQ-1:0]  plain_req;
    logic [IDW-1:0]    grant_id;
    logic              grant_any;
    logic              grant_err;
    imem_cmd_e         g_cmd;
    logic [ADDR_W-1:0] g_addr;
    logic [DATA_W-1:0] g_wdata;

    // Eligible requesters: valid and not stalled by another's lock.
    always_comb begin
        elig = req_valid & ~blocked;
        for (int i = 0; i < N_REQ; i++) begin
            plain_req[i] = req_valid[i] && (imem_cmd_e'(req_cmd[i]) == CMD_READ ||
                                            imem_cmd_e'(req_cmd[i]) == CMD_WRITE);
        end
    end

    // Select the granted requester's command fields.
    always_comb begin
        g_cmd   = imem_cmd_e'(req_cmd[grant_id]);
        g_addr  = req_addr[grant_id];
        g_wdata = req_wdata[grant_id];
    end

    assign req_ready = grant;

    imem_rr_arb #(.N_REQ(N_REQ), .IDW(IDW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig),
        .grant     (grant),
        .grant_id  (grant_id),
        .grant_any (grant_any)
    );

    imem_lock_table #(
        .N_REQ(N_REQ), .IDW(IDW), .ADDR_W(ADDR_W), .LOCK_SHIFT(LOCK_SHIFT)
    ) u_locks (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_cmd   (req_cmd),
        .req_addr  (req_addr),
        .grant_any (grant_any),
        .grant_id  (grant_id),
        .blocked   (blocked),
        .grant_err (grant_err)
    );

    imem_store #(.IDW(IDW), .WIDX_W(WIDX_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (grant_any),
        .cmd       (g_cmd),
        .word_idx  (g_addr[ADDR_W-1:2]),
        .wdata     (g_wdata),
        .id        (grant_id),
        .err       (grant_err),
        .rsp_valid (rsp_valid),
        .rsp_id    (rsp_id),
        .rsp_data  (rsp_data),
        .rsp_err   (rsp_err)
    );

    // R4
    plain_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|plain_req) |-> grant_any);
    // R8
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);
endmodule

// File: tb/tb_imem_interlock_arbiter.sv
`timescale 1ns/1ps
// Harness: one DUT with a behavioural per-cycle model and scripted requesters.
module imem_harness #(
    parameter int LS = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic done,
    output int   n_chk,
    output int   n_fail
);
    typedef struct packed {
        logic [1:0]  cmd;
        logic [7:0]  addr;
        logic [31:0] data;
    } op_t;

    logic [2:0]        req_valid;
    logic [2:0]        req_ready;
    logic [2:0][1:0]   req_cmd;
    logic [2:0][7:0]   req_addr;
    logic [2:0][31:0]  req_wdata;
    logic              rsp_valid;
    logic [1:0]        rsp_id;
    logic [31:0]       rsp_data;
    logic              rsp_err;

    imem_interlock_arbiter #(.N_REQ(3), .ADDR_W(8), .DATA_W(32), .LOCK_SHIFT(LS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    op_t         q [3][$];
    logic [31:0] m_mem [64];
    bit          lk_v [3];
    int          lk_t [3];
    int          ptr;
    bit          first_arb;
    bit          e_rv;
    int          e_id;
    logic [31:0] e_data;
    bit          e_err;
    string       e_tag;

    function automatic int rmask(logic [7:0] a);
        return int'(a) & ~((1 << LS) - 1) & 255;
    endfunction

    function automatic bit held_any(logic [7:0] a);
        for (int j = 0; j < 3; j++) if (lk_v[j] && lk_t[j] == rmask(a)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s (shift=%0d) actual=%0h expected=%0h", tag, what, LS, act, exp);
        end
    endtask

    task automatic push(int r, logic [1:0] c, logic [7:0] a, logic [31:0] d);
        op_t op;
        op.cmd = c; op.addr = a; op.data = d;
        q[r].push_back(op);
    endtask

    // Present each requester's head command.
    task automatic drive();
        for (int i = 0; i < 3; i++) begin
            if (q[i].size() > 0) begin
                req_valid[i] = 1'b1;
                req_cmd[i]   = q[i][0].cmd;
                req_addr[i]  = q[i][0].addr;
                req_wdata[i] = q[i][0].data;
            end else begin
                req_valid[i] = 1'b0;
                req_cmd[i]   = 2'd0;
                req_addr[i]  = 8'd0;
                req_wdata[i] = 32'd0;
            end
        end
    endtask

    // Compare outputs with the model, then advance the model by one edge.
    task automatic step();
        bit    el [3];
        int    g;
        int    wi;
        op_t   op;
        string tag;
        chk(rsp_valid == e_rv, e_rv ? e_tag : "R1", "rsp_valid", rsp_valid, e_rv);
        if (e_rv) begin
            chk(rsp_id == 2'(e_id), e_tag, "rsp_id", rsp_id, e_id);
            chk(rsp_data == e_data, e_tag, "rsp_data", rsp_data, e_data);
            chk(rsp_err == e_err, e_tag, "rsp_err", rsp_err, e_err);
        end
        for (int i = 0; i < 3; i++) begin
            el[i] = q[i].size() > 0;
            if (el[i] && q[i][0].cmd == 2'd2)
                for (int j = 0; j < 3; j++)
                    if (j != i && lk_v[j] && lk_t[j] == rmask(q[i][0].addr)) el[i] = 1'b0;
        end
        g = -1;
        for (int off = 0; off < 3; off++)
            if (g < 0 && el[(ptr + off) % 3]) g = (ptr + off) % 3;
        for (int i = 0; i < 3; i++) begin
            if (first_arb) tag = "R10";
            else if (q[i].size() > 0 && q[i][0].cmd == 2'd2) tag = (LS == 8) ? "R9" : "R3/R11";
            else if (q[i].size() > 0 && held_any(q[i][0].addr)) tag = "R4";
            else tag = "R8";
            chk(req_ready[i] == (g == i), tag, "req_ready", req_ready[i], (g == i));
        end
        e_rv = 1'b0;
        if (g >= 0) begin
            first_arb = 1'b0;
            op = q[g].pop_front();
            ptr = (g + 1) % 3;
            e_rv = 1'b1; e_id = g; e_err = 1'b0; e_data = 32'd0;
            wi = int'(op.addr[7:2]);
            case (op.cmd)
                2'd0: begin e_data = m_mem[wi]; e_tag = held_any(op.addr) ? "R4" : "R1"; end
                2'd1: begin e_tag = held_any(op.addr) ? "R4" : "R2"; m_mem[wi] = op.data; end
                2'd2: begin
                    if (lk_v[g]) begin e_err = 1'b1; e_tag = "R7"; end
                    else begin lk_v[g] = 1'b1; lk_t[g] = rmask(op.addr); e_data = m_mem[wi]; e_tag = "R3"; end
                end
                default: begin
                    if (lk_v[g] && lk_t[g] == rmask(op.addr)) begin
                        m_mem[wi] = op.data; lk_v[g] = 1'b0; e_tag = "R5";
                    end else begin e_err = 1'b1; e_tag = "R6"; end
                end
            endcase
        end
    endtask

    task automatic run_phase();
        while (q[0].size() + q[1].size() + q[2].size() > 0) begin
            @(posedge clk); #1 drive();
            @(negedge clk); step();
        end
        @(posedge clk); #1 drive();
        @(negedge clk); step();
    endtask

    initial begin
        int r;
        logic [7:0] a;
        done = 1'b0; n_chk = 0; n_fail = 0; ptr = 0; first_arb = 1'b1; e_rv = 1'b0;
        for (int i = 0; i < 3; i++) begin lk_v[i] = 1'b0; lk_t[i] = 0; end
        drive();
        @(negedge clk);
        // R10: reset state
        chk(rsp_valid == 1'b0, "R10", "rsp_valid in reset", rsp_valid, 0);
        while (!rst_n) @(negedge clk);
        chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", rsp_valid, 0);
        // Fill memory; all three start together to test first priority (R10).
        for (int w = 0; w < 64; w++) push(0, 2'd1, 8'(w * 4), 32'h5A00_0000 + 32'(w * 32'h0001_0203));
        push(1, 2'd1, 8'h80, 32'h1111_0001);
        push(2, 2'd1, 8'h84, 32'h2222_0002);
        run_phase();
        // Directed lock scenarios.
        push(0, 2'd2, 8'h10, 32'd0);
        push(0, 2'd2, 8'h10, 32'd0);
        push(0, 2'd3, 8'h11, 32'hAAAA_0001);
        push(1, 2'd2, 8'h12, 32'd0);
        push(1, 2'd3, 8'h12, 32'hBBBB_0002);
        push(1, 2'd3, 8'h20, 32'hDEAD_0000);
        push(2, 2'd0, 8'h10, 32'd0);
        push(2, 2'd1, 8'h10, 32'hCCCC_0003);
        push(2, 2'd2, 8'h40, 32'd0);
        push(2, 2'd3, 8'h44, 32'hEEEE_0004);
        push(2, 2'd3, 8'h40, 32'hFFFF_0005);
        run_phase();
        push(0, 2'd0, 8'h10, 32'd0);
        push(1, 2'd0, 8'h40, 32'd0);
        push(2, 2'd0, 8'h44, 32'd0);
        run_phase();
        // Mixed traffic with heavy region contention.
        for (int i = 0; i < 3; i++) begin
            for (int k = 0; k < 40; k++) begin
                r = int'($urandom % 10);
                a = 8'($urandom % 32);
                if (r < 3) push(i, 2'd0, a, 32'd0);
                else if (r < 6) push(i, 2'd1, a, $urandom);
                else if (r < 9) begin
                    push(i, 2'd2, a, 32'd0);
                    push(i, 2'd3, {a[7:2], 2'($urandom % 4)}, $urandom);
                end else push(i, 2'd3, a, $urandom);
            end
        end
        run_phase();
        done = 1'b1;
    end
endmodule

// Bench top: one-word and whole-memory region settings under the same script.
module tb_imem_interlock_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dn_a, dn_b;
    int   ca, fa, cb, fb;

    always #2 clk = ~clk;

    imem_harness #(.LS(2)) u_word  (.clk(clk), .rst_n(rst_n), .done(dn_a), .n_chk(ca), .n_fail(fa));
    imem_harness #(.LS(8)) u_whole (.clk(clk), .rst_n(rst_n), .done(dn_b), .n_chk(cb), .n_fail(fb));

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
    end

    initial begin
        int cyc = 0;
        int total, fails;
        while (!(dn_a && dn_b) && cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        total = ca + cb;
        fails = fa + fb;
        if (!(dn_a && dn_b)) begin
            total++;
            fails++;
            $display("FAIL R8 watchdog: actual=not finished expected=finished");
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule